// File: doc/BRIEF.md
# Four-Channel Reloadable Down-Counter Timer Bank

This block holds four programmable down-counting timers behind a small register write and read port. Channels 1 and 2 are 16 bits wide. Channels 3 and 4 are 32 bits wide. All four count on a shared timer tick. The tick is derived from a 2 MHz reference strobe at one of four selectable rates. The rate is produced as a single-cycle enable, so every register runs on the one system clock.

Software sets a reload value for each channel. The new value is copied into the counter on the next timer tick, whether or not the channel is running. A running channel steps down once per tick. When it reaches zero it refills itself from its reload value. If interrupts are enabled for that channel, this sets a sticky cause flag. All cause flags feed one shared interrupt line. Several channels can be waiting behind that line at once. Software clears each flag either by writing a 0 to its bit in the cause register, or by writing anything to that channel's own clear address.

Top module: `tmr_bank`

## Requirements
- R1: The rate select (control bits 9:8) gates the reference strobe. Counting the reference pulses from 0 since reset, a timer tick occurs on every pulse whose index is a multiple of 2^select. So 00 gives every pulse (2 MHz), 01 every 2nd pulse (1 MHz), 10 every 4th pulse (500 kHz) and 11 every 8th pulse (250 kHz). No tick occurs without a reference pulse.
- R2: On a tick, an enabled channel with no pending load and a nonzero count decreases by one. A disabled channel, or any channel between ticks, keeps its count.
- R3: On a tick where an enabled channel with no pending load holds 0, that is its terminal count. It refills from its reload value, so it repeats every reload+1 ticks.
- R4: Writing a channel's reload field marks a pending load. The first tick after the write cycle copies the reload value into the counter, whether the channel is enabled or not. That tick does not decrement.
- R5: Address 2 holds channel 1's reload in bits 15:0 and channel 2's in bits 31:16. Byte enables pick the half that is written. A half-write changes neither the other half nor the other channel's count. Addresses 3 and 4 hold the 32-bit reload values of channels 3 and 4.
- R6: A terminal count sets that channel's cause flag (address 1, bit n-1 for channel n) only if the channel's interrupt enable is 1. A set flag stays set until it is cleared.
- R7: A write to address 1 with byte enable 0 set clears every cause flag whose data bit is 0. It leaves the flags whose data bit is 1 unchanged. A terminal count in the same cycle as a clear wins.
- R8: Any write to address 7+n clears channel n's cause flag, whatever the data and byte enables are.
- R9: The interrupt output is high exactly while at least one cause flag is set.
- R10: After reset, the enables, interrupt enables, rate select, cause flags, reload values, counts and interrupt output are all 0.
- R11: Address 0 bits 3:0 are the channel enables and bits 7:4 are the interrupt enables, both written through byte 0. Bits 9:8 are the rate select, written through byte 1. Address 5 reads channel 2's count in bits 31:16 and channel 1's in bits 15:0. Addresses 6 and 7 read channels 3 and 4. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | Single-cycle 2 MHz reference strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
Deterministic bursts of reference pulses after a fresh reset pin down exact counts. With the same reload and seventeen pulses, rate selects 01 and 11 give different counts, which separates the divider ratios. A single channel is also stepped right up to its terminal count and one tick past it. Loads written while a channel is disabled, and half-word reload writes, separate the pending-load path from the counting path. Longer runs with the reference strobe at several spacings keep all four channels wrapping and overlapping their flags. These runs also mix both clear methods with the write-a-1-keeps rule, to show that the shared interrupt tracks the flags.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_CAUSE = 4'd1;
  localparam logic [3:0] A_LD12  = 4'd2;
  localparam logic [3:0] A_LD3   = 4'd3;
  localparam logic [3:0] A_LD4   = 4'd4;
  localparam logic [3:0] A_CT12  = 4'd5;
  localparam logic [3:0] A_CT3   = 4'd6;
  localparam logic [3:0] A_CT4   = 4'd7;
  localparam logic [3:0] A_CLR0  = 4'd8;

  // width of channel idx (0-based): first two are short
  function automatic int tmr_width(input int idx, input int ws, input int wl);
    return (idx < 2) ? ws : wl;
  endfunction

  // tick when the low 'sel' bits of the pulse index are zero
  function automatic logic rate_hit(input logic [2:0] div, input logic [1:0] sel);
    logic [3:0] mask;
    mask = (4'd1 << sel) - 4'd1;
    return (({1'b0, div} & mask) == 4'd0);
  endfunction

  // byte-lane merge of a register write
  function automatic logic [31:0] merge_be(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/tmr_rate_gen.sv
`timescale 1ns/1ps
module tmr_rate_gen #(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (ref_pulse) div_q <= div_q + 1'b1;
  end

  assign tick = ref_pulse && tmr_pkg::rate_hit(div_q[2:0], sel);

  AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ref_pulse);                                              // R1
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && sel == 2'd0) |-> tick);                             // R1
  AST_NO_ADJ_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 2'd0) |=> (!tick || sel != $past(sel)));          // R1
endmodule

// File: rtl/tmr_cell.sv
`timescale 1ns/1ps
module tmr_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         tc_evt
);
  logic         pend_q;
  logic [W-1:0] nxt;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                               input logic [W-1:0] ld,
                                               input logic pend,
                                               input logic en);
    if (pend)            return ld;
    if (!en)             return c;
    if (c == '0)         return ld;
    return c - 1'b1;
  endfunction

  assign nxt    = next_count(count, load_val, pend_q, run);
  assign tc_evt = tick && !pend_q && run && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      count  <= '0;
    end else begin
      if (load_wr)   pend_q <= 1'b1;
      else if (tick) pend_q <= 1'b0;
      if (tick) count <= nxt;
    end
  end

  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |=> count == $past(load_val));                   // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && run && count != '0) |=> count == W'($past(count) - 1'b1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));                                        // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> count == $past(load_val));                             // R3
endmodule

// File: rtl/tmr_cause.sv
`timescale 1ns/1ps
module tmr_cause #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_req) | set_evt;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);                                       // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr_req[i]) |=> flags[i]);                        // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !set_evt[i]) |=> !flags[i]);                     // R7
  end
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank #(
  parameter int W_SHORT = 16,
  parameter int W_LONG  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_pulse,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq
);
  import tmr_pkg::*;

  localparam int N_TMR = 4;
  localparam int HALF  = 16;

  logic [N_TMR-1:0] en_q, ie_q;
  logic [1:0]       sel_q;
  logic [31:0]      ld_q  [N_TMR];
  logic [31:0]      cnt_w [N_TMR];
  logic [N_TMR-1:0] ld_wr, tc_evt, set_evt, clr_req, flags;
  logic             tick;

  // named write events
  logic hit_ctrl, hit_cause, hit_ld12, hit_ld3, hit_ld4;
  assign hit_ctrl  = wr_en && wr_addr == A_CTRL;
  assign hit_cause = wr_en && wr_addr == A_CAUSE;
  assign hit_ld12  = wr_en && wr_addr == A_LD12;
  assign hit_ld3   = wr_en && wr_addr == A_LD3;
  assign hit_ld4   = wr_en && wr_addr == A_LD4;

  assign ld_wr[0] = hit_ld12 && |wr_be[1:0];
  assign ld_wr[1] = hit_ld12 && |wr_be[3:2];
  assign ld_wr[2] = hit_ld3  && |wr_be;
  assign ld_wr[3] = hit_ld4  && |wr_be;

  for (genvar i = 0; i < N_TMR; i++) begin : g_clr
    assign clr_req[i] = (hit_cause && wr_be[0] && !wr_data[i]) ||
                        (wr_en && wr_addr == (A_CLR0 + 4'(i)));
  end

  // control and reload registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ie_q  <= '0;
      sel_q <= '0;
      for (int i = 0; i < N_TMR; i++) ld_q[i] <= '0;
    end else begin
      if (hit_ctrl && wr_be[0]) begin
        en_q <= wr_data[3:0];
        ie_q <= wr_data[7:4];
      end
      if (hit_ctrl && wr_be[1]) sel_q <= wr_data[9:8];
      if (hit_ld12) begin
        ld_q[0] <= merge_be(ld_q[0], {16'b0, wr_data[15:0]},  {2'b00, wr_be[1:0]});
        ld_q[1] <= merge_be(ld_q[1], {16'b0, wr_data[31:16]}, {2'b00, wr_be[3:2]});
      end
      if (hit_ld3) ld_q[2] <= merge_be(ld_q[2], wr_data, wr_be);
      if (hit_ld4) ld_q[3] <= merge_be(ld_q[3], wr_data, wr_be);
    end
  end

  tmr_rate_gen #(.DIV_W(3)) u_rate (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .sel(sel_q), .tick(tick)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam int W = tmr_width(i, W_SHORT, W_LONG);
    logic [W-1:0] cval;
    tmr_cell #(.W(W)) u_cell (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(en_q[i]),
      .load_wr(ld_wr[i]), .load_val(ld_q[i][W-1:0]),
      .count(cval), .tc_evt(tc_evt[i])
    );
    assign cnt_w[i] = 32'(cval);
  end

  assign set_evt = tc_evt & ie_q;

  tmr_cause #(.N(N_TMR)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_req(clr_req), .flags(flags)
  );

  assign irq = |flags;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {22'b0, sel_q, ie_q, en_q};
      A_CAUSE: rd_data = {28'b0, flags};
      A_LD12:  rd_data = ld_q[0] | (ld_q[1] << HALF);
      A_LD3:   rd_data = ld_q[2];
      A_LD4:   rd_data = ld_q[3];
      A_CT12:  rd_data = cnt_w[0] | (cnt_w[1] << HALF);
      A_CT3:   rd_data = cnt_w[2];
      A_CT4:   rd_data = cnt_w[3];
      default: rd_data = '0;
    endcase
  end

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clr_req == '0) |=> irq);                                  // R9
  AST_IRQ_FROM_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> irq);                                         // R9
  AST_MASKED_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (tc_evt & ie_q) == '0 && !hit_cause) |=> !irq);          // R6
endmodule

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_pulse = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0, bad = 0;
  bit started = 0, finished = 0;

  // stimulus control (written by main, read by driver loop)
  int ref_mode = 0;      // 0 off, 1 periodic, 2 burst
  int ref_period = 1;
  int burst_budget = 0;
  bit scan = 0;
  logic [3:0] req_addr = '0;
  int burst_used = 0, ph = 0, sc = 0;

  always #2.5 clk = ~clk;

  tmr_bank u0 (.clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .wr_en(wr_en),
               .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
               .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  // reference model state
  int unsigned m_cnt[4], m_ld[4];
  bit m_pend[4], m_en[4], m_ie[4], m_flag[4];
  int m_sel, m_div;

  function automatic int unsigned wmask(int i);
    return (i < 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic int unsigned bytes_in(int unsigned old_v, int unsigned new_v, logic [3:0] be);
    int unsigned r = old_v;
    for (int b = 0; b < 4; b++)
      if (be[b]) r = (r & ~(32'hFF << (8*b))) | (new_v & (32'hFF << (8*b)));
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = 0; m_ld[i] = 0; m_pend[i] = 0; m_en[i] = 0; m_ie[i] = 0; m_flag[i] = 0;
      end
      m_sel = 0; m_div = 0;
    end else begin
      bit tk;
      bit ldw[4], clr[4], st[4];
      tk = ref_pulse && ((m_div % (1 << m_sel)) == 0);
      if (ref_pulse) m_div = (m_div + 1) % 8;
      ldw[0] = wr_en && wr_addr == 2 && (wr_be[0] || wr_be[1]);
      ldw[1] = wr_en && wr_addr == 2 && (wr_be[2] || wr_be[3]);
      ldw[2] = wr_en && wr_addr == 3 && wr_be != 0;
      ldw[3] = wr_en && wr_addr == 4 && wr_be != 0;
      for (int i = 0; i < 4; i++) begin
        st[i] = 0;
        if (tk) begin
          if (m_pend[i]) m_cnt[i] = m_ld[i];
          else if (m_en[i]) begin
            if (m_cnt[i] == 0) begin m_cnt[i] = m_ld[i]; st[i] = m_ie[i]; end
            else m_cnt[i] = m_cnt[i] - 1;
          end
        end
        clr[i] = (wr_en && wr_addr == 1 && wr_be[0] && !wr_data[i]) ||
                 (wr_en && wr_addr == 4'(8 + i));
        if (ldw[i]) m_pend[i] = 1; else if (tk) m_pend[i] = 0;
        m_flag[i] = (m_flag[i] && !clr[i]) || st[i];
      end
      if (wr_en && wr_addr == 0 && wr_be[0])
        for (int i = 0; i < 4; i++) begin m_en[i] = wr_data[i]; m_ie[i] = wr_data[4+i]; end
      if (wr_en && wr_addr == 0 && wr_be[1]) m_sel = int'(wr_data[9:8]);
      if (wr_en && wr_addr == 2) begin
        m_ld[0] = bytes_in(m_ld[0], wr_data & 32'hFFFF, {2'b00, wr_be[1:0]}) & wmask(0);
        m_ld[1] = bytes_in(m_ld[1], wr_data >> 16,      {2'b00, wr_be[3:2]}) & wmask(1);
      end
      if (wr_en && wr_addr == 3) m_ld[2] = bytes_in(m_ld[2], wr_data, wr_be);
      if (wr_en && wr_addr == 4) m_ld[3] = bytes_in(m_ld[3], wr_data, wr_be);
    end
  end

  function automatic logic [31:0] model_read(logic [3:0] a);
    case (a)
      0: return {22'b0, 2'(m_sel), m_ie[3], m_ie[2], m_ie[1], m_ie[0],
                 m_en[3], m_en[2], m_en[1], m_en[0]};
      1: return {28'b0, m_flag[3], m_flag[2], m_flag[1], m_flag[0]};
      2: return (m_ld[1] << 16) | m_ld[0];
      3: return m_ld[2];
      4: return m_ld[3];
      5: return (m_cnt[1] << 16) | m_cnt[0];
      6: return m_cnt[2];
      7: return m_cnt[3];
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] a);
    case (a)
      0: return "R11"; 1: return "R6"; 2, 3, 4: return "R5";
      5, 6, 7: return "R2"; default: return "R11";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R9 on irq)
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R9", {31'b0, irq}, {31'b0, (m_flag[0] | m_flag[1] | m_flag[2] | m_flag[3])});
      chk(req_of(rd_addr), rd_data, model_read(rd_addr));
    end
  end

  // sole driver of ref_pulse and rd_addr
  initial begin
    forever begin
      @(negedge clk); #1;
      if (ref_mode == 1) begin
        ref_pulse = (ph % ref_period) == 0; ph++;
      end else if (ref_mode == 2 && burst_used < burst_budget) begin
        ref_pulse = 1'b1; burst_used++;
      end else ref_pulse = 1'b0;
      if (scan) begin rd_addr = 4'(sc % 12); sc++; end
      else rd_addr = req_addr;
    end
  end

  task automatic wr(logic [3:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic burst(int n);
    ref_mode = 2; burst_budget = burst_budget + n;
    wait (burst_used == burst_budget);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    req_addr = a;
    @(negedge clk); @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    started = 1;
    // R10 reset state
    rd(4'd0, 32'h0, "R10"); rd(4'd1, 32'h0, "R10");
    rd(4'd5, 32'h0, "R10"); rd(4'd6, 32'h0, "R10");
    chk("R10", {31'b0, irq}, 32'h0);

    // R4/R5: load while disabled, low half only
    wr(4'd2, 4'b0011, 32'h0003_0009);
    burst(2);
    rd(4'd5, 32'h0000_0009, "R4");
    rd(4'd2, 32'h0000_0009, "R5");
    wr(4'd2, 4'b1100, 32'h0003_0000);
    burst(2);
    rd(4'd5, 32'h0003_0009, "R5");
    burst(3);
    rd(4'd5, 32'h0003_0009, "R2");   // disabled: holds

    // R3/R6: channel 3 reload 2 to terminal count
    do_reset();
    wr(4'd3, 4'b1111, 32'h2);
    wr(4'd0, 4'b0011, 32'h0000_0044);   // en3, ie3, sel 0
    burst(3);                            // load 2, then 1, 0
    rd(4'd6, 32'h0, "R3");
    rd(4'd1, 32'h0, "R6");
    burst(1);                            // terminal count -> reload
    rd(4'd6, 32'h2, "R3");
    rd(4'd1, 32'h4, "R6");
    chk("R9", {31'b0, irq}, 32'h1);
    // R7: writing 1 keeps, 0 clears; R8 clear register
    wr(4'd0, 4'b0001, 32'h0000_0041);   // en1 + ie3 (ch3 stops)
    wr(4'd2, 4'b0011, 32'h0000_0000);
    burst(2);                           // load 0, then terminal count on ch1 (ie1=0)
    rd(4'd1, 32'h4, "R6");              // no flag without interrupt enable
    wr(4'd1, 4'b0001, 32'h0000_000F);
    rd(4'd1, 32'h4, "R7");
    wr(4'd9, 4'b0001, 32'h0);           // clear ch2: no effect on ch3
    rd(4'd1, 32'h4, "R8");
    wr(4'd10, 4'b0000, 32'hFFFF_FFFF);  // clear ch3, no byte enables
    rd(4'd1, 32'h0, "R8");
    chk("R9", {31'b0, irq}, 32'h0);

    // R1: 17 pulses, reload 100 on ch4
    do_reset();
    wr(4'd4, 4'b1111, 32'd100);
    wr(4'd0, 4'b0011, 32'h0000_0308);   // en4, sel 11
    burst(17);                          // ticks at 0,8,16
    rd(4'd7, 32'd98, "R1");
    rd(4'd0, 32'h0000_0308, "R11");
    do_reset();
    wr(4'd4, 4'b1111, 32'd100);
    wr(4'd0, 4'b0011, 32'h0000_0108);   // sel 01
    burst(17);                          // 9 ticks
    rd(4'd7, 32'd92, "R1");
    rd(4'd8, 32'h0, "R11");

    // long mixed runs checked against the model every cycle
    do_reset();
    scan = 1;
    wr(4'd2, 4'b1111, 32'h0004_0006);
    wr(4'd3, 4'b1111, 32'd5);
    wr(4'd4, 4'b1111, 32'd11);
    wr(4'd0, 4'b0011, 32'h0000_00FF);
    ref_mode = 1; ref_period = 3;
    run(300);
    wr(4'd1, 4'b0001, 32'h0000_000A);   // R7 clear bits 0 and 2
    run(100);
    wr(4'd9, 4'b1111, 32'h0);           // R8
    wr(4'd11, 4'b0001, 32'h0);
    wr(4'd0, 4'b0010, 32'h0000_0100);   // sel 01
    ref_period = 2;
    run(300);
    wr(4'd0, 4'b0010, 32'h0000_0200);
    wr(4'd4, 4'b0001, 32'h0000_0003);
    ref_period = 1;
    run(300);
    wr(4'd0, 4'b0011, 32'h0000_03CF);   // ie only on ch3/ch4
    run(300);
    wr(4'd1, 4'b0001, 32'h0);
    wr(4'd0, 4'b0011, 32'h0000_0300);
    run(200);
    wr(4'd1, 4'b0001, 32'h0);
    run(20);
    chk("R9", {31'b0, irq}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule